// File: doc/BRIEF.md
# Branch and Skip Next-Address Unit

This unit works out the next program-counter value for the control-flow opcodes of an 8-bit accumulator processor. The core presents four things together with a one-cycle `in_valid` strobe:

- the opcode;
- the current 16-bit PC, which already points at the byte after the opcode;
- up to two operand bytes fetched from that position;
- the condition sources: four external sense flags, the Q output latch, the carry flag, a D-is-zero indication and interrupt enable.

One clock later the unit returns the registered next PC. It also reports whether the second operand byte was really consumed, and whether the opcode lay outside the handled groups.

There are three opcode groups:

- **Short branches (0x30–0x3F).** When taken, they replace only the low byte of the PC and keep the current page. When not taken, they step over the single operand byte.
- **Long branches (0xC0–0xC3, 0xC8–0xCB).** When taken, they load a full 16-bit address, high byte first. When not taken, they step over both operand bytes.
- **Long skips (0xC4–0xC7, 0xCC–0xCF).** They either jump two bytes ahead with no operand fetch or continue in place.

In every group, opcode bit 3 selects the complemented form of the condition.

Top module: `bss_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `out_valid`=0, `next_pc`=0, `fetch_second`=0 and `bad_op`=0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. While `in_valid` is low, `next_pc`, `fetch_second` and `bad_op` keep their values.
- R3: For opcode 0x30+k, bits [2:0] select the condition: 0 = always, 1 = Q, 2 = D zero, 3 = carry, 4..7 = `ext_flag[0]`..`ext_flag[3]`. Opcode bit 3 set inverts the condition, so 0x38 is never taken.
- R4: A taken short branch gives `next_pc` = {`cur_pc[15:8]`, `opnd_a`}. A not-taken short branch gives `cur_pc`+1. `fetch_second` is 0 in both cases.
- R5: For long branches 0xC0–0xC3 and 0xC8–0xCB, bits [1:0] select the condition: 0 = always, 1 = Q, 2 = D zero, 3 = carry. Bit 3 inverts it.
- R6: A taken long branch gives `next_pc` = {`opnd_a`, `opnd_b`} with `fetch_second`=1. A not-taken long branch gives `cur_pc`+2 with `fetch_second`=0.
- R7: The long skips skip on these conditions: 0xC5 Q=0, 0xC6 D nonzero, 0xC7 carry=0, 0xCC interrupt enable=1, 0xCD Q=1, 0xCE D zero, 0xCF carry=1. A skip gives `cur_pc`+2; otherwise the result is `cur_pc`. `fetch_second` is 0 in both cases.
- R8: Opcode 0xC4 gives `next_pc` = `cur_pc` regardless of the flags.
- R9: Any opcode outside 0x30–0x3F and 0xC0–0xCF gives `cur_pc`+1 with `bad_op`=1. Every opcode inside those ranges gives `bad_op`=0.
- R10: PC increments wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe: the inputs below are sampled this cycle |
| opcode | input | 8 | Opcode under evaluation |
| cur_pc | input | 16 | PC pointing at the first operand byte |
| opnd_a | input | 8 | First operand byte (page offset, or high address byte) |
| opnd_b | input | 8 | Second operand byte (low address byte) |
| ext_flag | input | 4 | External sense flags 1..4 |
| q_flag | input | 1 | Q output latch state |
| df_flag | input | 1 | Carry/borrow flag |
| d_zero | input | 1 | Accumulator equals zero |
| int_en | input | 1 | Interrupt enable |
| out_valid | output | 1 | Result valid |
| next_pc | output | 16 | Computed next PC |
| fetch_second | output | 1 | Second operand byte was consumed |
| bad_op | output | 1 | Opcode outside the handled groups |

## Verification
The unit holds no state apart from its output register, so a wrong internal decision shows up in `next_pc` in the very next cycle after the strobe. A wrongly selected or inverted condition appears as the taken and not-taken results being swapped for one flag pattern. A wrong group decode appears as a wrong step size (0, 1 or 2), a wrong `fetch_second`, or a spurious `bad_op`. Because of this, each opcode is exercised under several flag patterns, including the complemented forms. Page and wrap boundaries of the PC are probed separately.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int FLAG_N = 4;

  typedef enum logic [1:0] {
    GRP_SHORT = 2'd0,
    GRP_LBR   = 2'd1,
    GRP_LSKP  = 2'd2,
    GRP_NONE  = 2'd3
  } grp_e;

  function automatic grp_e classify(input logic [7:0] op);
    if (op[7:4] == 4'h3) return GRP_SHORT;
    if (op[7:4] == 4'hC) return op[2] ? GRP_LSKP : GRP_LBR;
    return GRP_NONE;
  endfunction
endpackage

// File: rtl/bss_cond.sv
module bss_cond
  import bss_pkg::*;
(
  input  logic [2:0]        sel,
  input  logic [FLAG_N-1:0] ext_flag,
  input  logic              q_flag,
  input  logic              df_flag,
  input  logic              d_zero,
  output logic              hit
);
  localparam int SRC_N = 4 + FLAG_N;

  logic [SRC_N-1:0] src;

  assign src[0] = 1'b1;
  assign src[1] = q_flag;
  assign src[2] = d_zero;
  assign src[3] = df_flag;

  generate
    for (genvar i = 0; i < FLAG_N; i++) begin : g_ef
      assign src[4+i] = ext_flag[i];
    end
  endgenerate

  assign hit = src[sel];
endmodule

// File: rtl/bss_target.sv
module bss_target
  import bss_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  grp_e                grp,
  input  logic                inv,
  input  logic [1:0]          lo,
  input  logic                hit,
  input  logic                int_en,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [PC_W/2-1:0]   opnd_a,
  input  logic [PC_W/2-1:0]   opnd_b,
  output logic [PC_W-1:0]     nxt,
  output logic                fetch2,
  output logic                bad
);
  localparam int BYTE_W = PC_W / 2;

  logic [PC_W-1:0] pc_p1, pc_p2;
  logic            take, skip;

  assign pc_p1 = cur_pc + PC_W'(1);
  assign pc_p2 = cur_pc + PC_W'(2);
  assign take  = hit ^ inv;
  // Skips use the true form when bit 3 is set; a zero selector means
  // interrupt enable (bit 3 set) or a plain no-op (bit 3 clear).
  assign skip  = (lo == 2'd0) ? (inv & int_en) : (hit ^ ~inv);

  always_comb begin
    nxt    = pc_p1;
    fetch2 = 1'b0;
    bad    = 1'b0;
    unique case (grp)
      GRP_SHORT: nxt = take ? {cur_pc[PC_W-1:BYTE_W], opnd_a} : pc_p1;
      GRP_LBR: begin
        nxt    = take ? {opnd_a, opnd_b} : pc_p2;
        fetch2 = take;
      end
      GRP_LSKP: nxt = skip ? pc_p2 : cur_pc;
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/bss_seq.sv
module bss_seq
  import bss_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [7:0]          opcode,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [PC_W/2-1:0]   opnd_a,
  input  logic [PC_W/2-1:0]   opnd_b,
  input  logic [FLAG_N-1:0]   ext_flag,
  input  logic                q_flag,
  input  logic                df_flag,
  input  logic                d_zero,
  input  logic                int_en,
  output logic                out_valid,
  output logic [PC_W-1:0]     next_pc,
  output logic                fetch_second,
  output logic                bad_op
);
  grp_e            grp;
  logic [2:0]      sel;
  logic            hit;
  logic [PC_W-1:0] nxt;
  logic            fetch2, bad;

  assign grp = classify(opcode);
  assign sel = (grp == GRP_SHORT) ? opcode[2:0] : {1'b0, opcode[1:0]};

  bss_cond cond_i (
    .sel      (sel),
    .ext_flag (ext_flag),
    .q_flag   (q_flag),
    .df_flag  (df_flag),
    .d_zero   (d_zero),
    .hit      (hit)
  );

  bss_target #(.PC_W(PC_W)) tgt_i (
    .grp    (grp),
    .inv    (opcode[3]),
    .lo     (opcode[1:0]),
    .hit    (hit),
    .int_en (int_en),
    .cur_pc (cur_pc),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .nxt    (nxt),
    .fetch2 (fetch2),
    .bad    (bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      next_pc      <= '0;
      fetch_second <= 1'b0;
      bad_op       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc      <= nxt;
        fetch_second <= fetch2;
        bad_op       <= bad;
      end
    end
  end
endmodule

// File: rtl/bss_seq_chk.sv
module bss_seq_chk #(
  parameter int PC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [PC_W-1:0]   cur_pc,
  input logic              out_valid,
  input logic [PC_W-1:0]   next_pc,
  input logic              fetch_second,
  input logic              bad_op
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && next_pc == '0 && !fetch_second && !bad_op));

  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(next_pc) && $stable(fetch_second) && $stable(bad_op)));

  p_short_page_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] == 4'h3) |=>
      (!fetch_second && !bad_op &&
       (next_pc[PC_W-1:PC_W/2] == $past(cur_pc[PC_W-1:PC_W/2]) ||
        next_pc == $past(cur_pc) + PC_W'(1))));

  p_lbr_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] == 4'hC && !opcode[2]) |=>
      (fetch_second || next_pc == $past(cur_pc) + PC_W'(2)));

  p_skip_step_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] == 4'hC && opcode[2]) |=>
      (!fetch_second && !bad_op &&
       (next_pc == $past(cur_pc) || next_pc == $past(cur_pc) + PC_W'(2))));

  p_nop_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 8'hC4) |=> (next_pc == $past(cur_pc)));

  p_bad_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7:4] != 4'h3 && opcode[7:4] != 4'hC) |=>
      (bad_op && !fetch_second && next_pc == $past(cur_pc) + PC_W'(1)));
endmodule

bind bss_seq bss_seq_chk #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .opcode       (opcode),
  .cur_pc       (cur_pc),
  .out_valid    (out_valid),
  .next_pc      (next_pc),
  .fetch_second (fetch_second),
  .bad_op       (bad_op)
);

// File: tb/bss_seq_tb_top.sv
`timescale 1ns/1ps
module bss_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] cur_pc = 16'h0000;
  logic [7:0]  opnd_a = 8'h00, opnd_b = 8'h00;
  logic [3:0]  ext_flag = 4'h0;
  logic        q_flag = 1'b0, df_flag = 1'b0, d_zero = 1'b0, int_en = 1'b0;
  logic        out_valid, fetch_second, bad_op;
  logic [15:0] next_pc;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bss_seq dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .cur_pc(cur_pc), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ext_flag(ext_flag), .q_flag(q_flag), .df_flag(df_flag),
    .d_zero(d_zero), .int_en(int_en),
    .out_valid(out_valid), .next_pc(next_pc),
    .fetch_second(fetch_second), .bad_op(bad_op)
  );

  // Reference model written from the requirements, opcode by opcode.
  function automatic void model(input logic [7:0] op, input logic [15:0] pc,
                                input logic [7:0] a, input logic [7:0] b,
                                output logic [15:0] npc, output logic f2,
                                output logic eb);
    logic c;
    npc = pc + 16'd1; f2 = 1'b0; eb = 1'b0;
    if (op >= 8'h30 && op <= 8'h3F) begin
      case (op & 8'hF7)
        8'h30: c = 1'b1;
        8'h31: c = q_flag;
        8'h32: c = d_zero;
        8'h33: c = df_flag;
        8'h34: c = ext_flag[0];
        8'h35: c = ext_flag[1];
        8'h36: c = ext_flag[2];
        default: c = ext_flag[3];
      endcase
      if (op >= 8'h38) c = !c;
      npc = c ? {pc[15:8], a} : pc + 16'd1;
    end else if (op inside {8'hC0, 8'hC1, 8'hC2, 8'hC3,
                            8'hC8, 8'hC9, 8'hCA, 8'hCB}) begin
      case (op)
        8'hC0: c = 1'b1;       8'hC8: c = 1'b0;
        8'hC1: c = q_flag;     8'hC9: c = !q_flag;
        8'hC2: c = d_zero;     8'hCA: c = !d_zero;
        8'hC3: c = df_flag;    default: c = !df_flag;
      endcase
      npc = c ? {a, b} : pc + 16'd2;
      f2  = c;
    end else if (op >= 8'hC4 && op <= 8'hCF) begin
      case (op)
        8'hC5: c = !q_flag;
        8'hC6: c = !d_zero;
        8'hC7: c = !df_flag;
        8'hCC: c = int_en;
        8'hCD: c = q_flag;
        8'hCE: c = d_zero;
        8'hCF: c = df_flag;
        default: c = 1'b0;
      endcase
      npc = c ? pc + 16'd2 : pc;
    end else begin
      eb = 1'b1;
    end
  endfunction

  task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (valid,pc,fetch2,bad)", req, got, exp);
    end
  endtask

  task automatic set_flags(input logic [7:0] p);
    {int_en, q_flag, df_flag, d_zero, ext_flag} = p;
  endtask

  task automatic run(input string req, input logic [7:0] op, input logic [15:0] pc,
                     input logic [7:0] a, input logic [7:0] b);
    logic [15:0] e_pc; logic e_f2, e_bad;
    @(negedge clk);
    opcode = op; cur_pc = pc; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    model(op, pc, a, b, e_pc, e_f2, e_bad);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, next_pc, fetch_second, bad_op}, {1'b1, e_pc, e_f2, e_bad});
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37) ^ 8'h5A;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", {out_valid, next_pc, fetch_second, bad_op}, 19'd0);
    rst = 1'b0;
  endtask

  task automatic t_short();
    for (int p = 0; p < 10; p++) begin
      set_flags(pat(p));
      for (int k = 0; k < 16; k++)
        run("R3/R4", 8'h30 + 8'(k), 16'h4A10 + 16'(p), 8'hC7, 8'h11);
    end
    set_flags(8'h00);
    run("R3", 8'h38, 16'h2000, 8'h55, 8'h00);
  endtask

  task automatic t_long_br();
    for (int p = 0; p < 10; p++) begin
      set_flags(pat(p));
      for (int k = 0; k < 4; k++) begin
        run("R5/R6", 8'hC0 + 8'(k), 16'h1234, 8'hBE, 8'hEF);
        run("R5/R6", 8'hC8 + 8'(k), 16'h1234, 8'hBE, 8'hEF);
      end
    end
  endtask

  task automatic t_long_skip();
    for (int p = 0; p < 10; p++) begin
      set_flags(pat(p));
      for (int k = 5; k < 8; k++) run("R7", 8'hC0 + 8'(k), 16'h0800, 8'h00, 8'h00);
      for (int k = 12; k < 16; k++) run("R7", 8'hC0 + 8'(k), 16'h0800, 8'h00, 8'h00);
    end
  endtask

  task automatic t_nop();
    set_flags(8'hFF);
    run("R8", 8'hC4, 16'h7777, 8'h12, 8'h34);
    set_flags(8'h00);
    run("R8", 8'hC4, 16'h0001, 8'h12, 8'h34);
  endtask

  task automatic t_bad();
    run("R9", 8'h00, 16'h1000, 8'h00, 8'h00);
    run("R9", 8'h2F, 16'h1000, 8'h00, 8'h00);
    run("R9", 8'h40, 16'h00FF, 8'h00, 8'h00);
    run("R9", 8'hBF, 16'h1000, 8'h00, 8'h00);
    run("R9", 8'hD0, 16'h1000, 8'h00, 8'h00);
    run("R9", 8'hFF, 16'h1000, 8'h00, 8'h00);
  endtask

  task automatic t_wrap();
    set_flags(8'h00);
    run("R10", 8'h38, 16'hFFFF, 8'h22, 8'h00);
    run("R10", 8'hC8, 16'hFFFE, 8'h00, 8'h00);
    d_zero = 1'b1;
    run("R10", 8'hCE, 16'hFFFF, 8'h00, 8'h00);
    run("R10", 8'h32, 16'hFFFF, 8'h80, 8'h00);
    run("R10", 8'h55, 16'hFFFF, 8'h00, 8'h00);
  endtask

  task automatic t_hold();
    logic [18:0] snap;
    set_flags(8'h00);
    run("R2", 8'hC0, 16'h0100, 8'hA1, 8'hB2);
    snap = {1'b0, next_pc, fetch_second, bad_op};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      opcode = 8'hF0; cur_pc = 16'h9999;
      check("R2", {out_valid, next_pc, fetch_second, bad_op}, snap);
    end
  endtask

  task automatic t_reset_mid();
    run("R6", 8'hC0, 16'h0000, 8'hFE, 8'hDC);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", {out_valid, next_pc, fetch_second, bad_op}, 19'd0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_short();
    t_long_br();
    t_long_skip();
    t_nop();
    t_bad();
    t_wrap();
    t_hold();
    t_reset_mid();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=running expected=done");
    finish_up();
  end
endmodule